// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A small binary counter that steps by one on each rising clock edge while its active-low enable is asserted, in the direction chosen by a single direction pin. An active-low parallel load forces the count to the data pins at once, without waiting for a clock edge, so the counter can start each run from any value. Reloading a fixed start value at every terminal count turns the block into a modulo-N divider.

Two cascade outputs report the terminal state of the current direction. The terminal flag is high for the whole cycle in which the count sits at all-ones while counting up, or at zero while counting down. The ripple output is active low. It repeats the same condition, but only during the low half of the clock. Stages that share one clock are chained by feeding the ripple output of one stage into the enable of the next. All pins are plain control and status levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `updn_casc_counter`

## Requirements
- R1: With enable low and direction low (0 = up), the count rises by one on each rising clock edge and wraps from 15 to 0.
- R2: With enable low and direction high (1 = down), the count falls by one on each rising clock edge and wraps from 0 to 15.
- R3: With enable high, a rising clock edge leaves the count unchanged in either direction.
- R4: While load is low, the output equals the data pins at once, whatever the clock level, and clock edges do not count. After load rises, counting resumes from the value that was loaded. The data pins must be held steady from the last clock edge or load fall until load rises.
- R5: Changes on the enable and direction pins between clock edges do not alter the count output.
- R6: The terminal flag is high exactly when (direction = 0 and count = 15) or (direction = 1 and count = 0). This holds whatever the enable level.
- R7: The ripple output is low exactly when the terminal flag is high and the clock is low. It is high during the whole high phase of the clock.
- R8: Loading 13, counting up five edges, holding one edge, then counting down five edges gives 14, 15, 0, 1, 2, then 2, then 1, 0, 15, 14, 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| load_n | input | 1 | Asynchronous parallel load, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | W (4) | Parallel load value |
| q | output | W (4) | Current count |
| term_flag | output | 1 | High while at the terminal value of the current direction |
| ripple_n | output | 1 | Low while at the terminal value and the clock is low |

## Verification
The bench starts from every one of the 16 values, in both directions and with enable on and off. It checks each wrap. A design that saturates or misses the carry would stop at 15 or at 0 instead of wrapping. It samples the ripple output in both clock phases. A version that ignores the clock would pulse low during the high phase, and one that looks at the enable would hide the flag while counting is held. The load checks read the output while the clock is low and again across a clock edge. A load made synchronous would show the old count until the next edge, and one with the wrong priority would count over the loaded value.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  function automatic dir_e to_dir(input logic down);
    return down ? DIR_DOWN : DIR_UP;
  endfunction
endpackage

// File: rtl/updn_step.sv
module updn_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  output logic [W-1:0] nxt
);
  import updn_pkg::*;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (to_dir(dir_down))
      DIR_UP:   nxt = cur + ONE;
      DIR_DOWN: nxt = cur - ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  output logic         at_term
);
  import updn_pkg::*;
  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
  localparam logic [W-1:0] BOT_VAL = {W{1'b0}};

  always_comb begin
    unique case (to_dir(dir_down))
      DIR_UP:   at_term = (cur == TOP_VAL);
      DIR_DOWN: at_term = (cur == BOT_VAL);
      default:  at_term = 1'b0;
    endcase
  end
endmodule

// File: rtl/updn_state.sv
module updn_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic         hold,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)   cnt <= din;
    else if (!hold) cnt <= nxt;
  end
endmodule

// File: rtl/updn_casc_counter.sv
module updn_casc_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic         cnt_en_n,
  input  logic         dir_down,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         term_flag,
  output logic         ripple_n
);
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic         at_term;

  updn_step #(.W(W)) u_step (
    .cur      (cnt),
    .dir_down (dir_down),
    .nxt      (cnt_nxt)
  );

  updn_state #(.W(W)) u_state (
    .clk    (clk),
    .load_n (load_n),
    .hold   (cnt_en_n),
    .nxt    (cnt_nxt),
    .din    (din),
    .cnt    (cnt)
  );

  // The output follows the data pins for as long as load is held low.
  assign q = load_n ? cnt : din;

  updn_term #(.W(W)) u_term (
    .cur      (q),
    .dir_down (dir_down),
    .at_term  (at_term)
  );

  assign term_flag = at_term;
  assign ripple_n  = ~(at_term & ~clk);
endmodule

// File: rtl/updn_casc_counter_chk.sv
module updn_casc_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         load_n,
  input logic         cnt_en_n,
  input logic         dir_down,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         term_flag,
  input logic         ripple_n
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // The count is unknown until the first load.
  logic armed = 1'b0;
  always @(negedge load_n) armed <= 1'b1;

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!armed || !load_n)
    ($past(armed) && $past(load_n) && !$past(cnt_en_n) && !$past(dir_down))
      |-> (q == $past(q) + ONE)); // R1

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!armed || !load_n)
    ($past(armed) && $past(load_n) && !$past(cnt_en_n) && $past(dir_down))
      |-> (q == $past(q) - ONE)); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!armed || !load_n)
    ($past(armed) && $past(load_n) && $past(cnt_en_n)) |-> $stable(q)); // R3

  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!armed)
    !load_n |-> (q == din)); // R4

  AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!armed)
    term_flag |-> (q == {W{1'b0}} || q == {W{1'b1}})); // R6

  AST_RIPPLE_LOW_PHASE: assert property (@(posedge clk) disable iff (!armed)
    ripple_n != term_flag); // R7

  AST_RIPPLE_HIGH_PHASE: assert property (@(negedge clk) disable iff (!armed)
    ripple_n); // R7
endmodule

bind updn_casc_counter updn_casc_counter_chk #(.W(W)) u_chk (.*);

// File: tb/sim_updn_casc_counter.sv
module sim_updn_casc_counter;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en_n = 1'b1;
  logic         dir_down = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         term_flag;
  logic         ripple_n;

  int checks = 0;
  int errors = 0;
  int expv = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_casc_counter #(.W(W)) u0 (
    .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
    .din(din), .q(q), .term_flag(term_flag), .ripple_n(ripple_n)
  );

  task automatic check(input string req, input int act, input int want);
    checks++;
    if (act != want) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, want, $time);
    end
  endtask

  function automatic int want_term(input int v, input bit dn);
    return dn ? int'(v == 0) : int'(v == 15);
  endfunction

  // Load v across one rising edge with the enable asserted, then release.
  task automatic do_load(input int v);
    @(negedge clk);
    cnt_en_n = 1'b0;
    load_n = 1'b0;
    din = W'(v);
    #1 check("R4 load while clock low", int'(q), v);
    @(posedge clk);
    #1 check("R4 load priority over edge", int'(q), v);
    #1 load_n = 1'b1;
    #1 check("R4 value held after release", int'(q), v);
    expv = v;
  endtask

  // One clock period: drive at the falling edge, check both phases.
  task automatic step(input bit dn, input bit en_n, input string req);
    @(negedge clk);
    dir_down = dn;
    cnt_en_n = en_n;
    #2;
    check("R6 flag in low phase", int'(term_flag), want_term(expv, dn));
    check("R7 ripple in low phase", int'(ripple_n), 1 - want_term(expv, dn));
    @(posedge clk);
    if (!en_n) expv = dn ? ((expv + 15) % 16) : ((expv + 1) % 16);
    #2;
    check(req, int'(q), expv);
    check("R6 flag in high phase", int'(term_flag), want_term(expv, dn));
    check("R7 ripple in high phase", int'(ripple_n), 1);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Initial state after a load of zero.
    do_load(0);
    check("R4 initial state", int'(q), 0);

    // Every start value, both directions, enable on and off.
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 2; e++) begin
          do_load(s);
          if (e == 1) step(bit'(d), 1'b1, "R3 hold with enable high");
          else if (d == 0) step(1'b0, 1'b0, "R1 count up");
          else step(1'b1, 1'b0, "R2 count down");
        end
      end
    end

    // Controls toggled between edges leave the count alone.
    do_load(7);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      cnt_en_n = i[0];
      dir_down = i[1];
      #1 check("R5 control change between edges", int'(q), 7);
    end
    cnt_en_n = 1'b1;
    @(posedge clk);
    #1 check("R5 held after edge", int'(q), 7);

    // Load data changed while load is held low.
    @(negedge clk);
    load_n = 1'b0;
    din = 4'd3;
    #1 check("R4 follows data", int'(q), 3);
    din = 4'd9;
    #1 check("R4 follows new data", int'(q), 9);
    @(posedge clk);
    #2 load_n = 1'b1;
    #1 check("R4 resumes from last data", int'(q), 9);
    expv = 9;
    step(1'b0, 1'b0, "R4 counts from loaded value");

    // Prescribed load, count, inhibit, count sequence.
    do_load(13);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R8 sequence up");
    check("R8 end of up run", int'(q), 2);
    step(1'b0, 1'b1, "R8 sequence inhibit");
    check("R8 inhibited value", int'(q), 2);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R8 sequence down");
    check("R8 end of down run", int'(q), 13);

    // Flags with counting inhibited at a terminal value.
    do_load(15);
    step(1'b0, 1'b1, "R6 flag with enable high");
    do_load(0);
    step(1'b1, 1'b1, "R6 flag at zero with enable high");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule